// File: doc/BRIEF.md
# Parallel Configuration Host Sequencer

This block sits on the host side of a fast passive parallel configuration link and loads a target device. A `start` pulse in idle begins a load. The block pulls the active-low configuration-reset strobe down for a fixed interval, then releases it. It waits for the target's status line to come back high, then waits a lead-in interval. After that it takes image words from a valid/ready stream and presents them on the parallel bus, one word per configuration clock.

The configuration clock is made by dividing the system clock. Its low and high phase lengths are parameters. A new word is loaded only at the start of a low phase, so the low phase gives setup time and the word stays put through the whole high phase. After the word flagged as last, the block waits for the target's done line. It then gives exactly two more clock falling edges so the target can initialise. Finally it waits for the init-done line. The bus width is 8 or 16 bits (`DW`). In 8-bit mode the upper byte of the 16-line bus is driven to zero.

The outcome of each load is held until the next start. It is one of: success (`ok`), aborted by the target (`err`), or timeout (`tmo`). In idle the bus output enable is low and the configuration clock sits low.

The sequencer states and their transitions are:
- IDLE → PULSE on `start`.
- PULSE → WSTAT when the pulse interval expires.
- WSTAT → LEAD when status is high, or → IDLE with a timeout.
- LEAD → FETCH when the lead-in interval expires.
- FETCH → LOW when a word is accepted.
- LOW → HIGH when the low phase expires.
- HIGH → FETCH after an ordinary word, or → WDONE after the last word.
- WDONE → XHIGH when done rises, or → IDLE with a timeout.
- XHIGH → XLOW when the high phase expires.
- XLOW → XHIGH after the first extra pulse, or → WINIT after the second.
- WINIT → IDLE with success when init-done rises, or → IDLE with a timeout.
- FETCH, LOW and HIGH each go → IDLE with an error if status drops.

Top module: `cfg_host_seq`

## Requirements
- R1: After reset, `cfg_rst_n` is 1, `dclk_o` is 0, `data_oe` is 0, and `busy`, `ok`, `err` and `tmo` are all 0.
- R2: A `start` in idle drives `cfg_rst_n` low for exactly `T_PULSE` system clock cycles.
- R3: Once `stat_i` is seen high after the pulse, the first rising edge of `dclk_o` comes no sooner than `T_LEAD + T_LO` cycles later.
- R4: Each accepted stream word appears on `data_o` at a rising edge of `dclk_o`, in stream order, one word per rising edge. All 16 lines carry the word when `DW` is 16.
- R5: `dclk_o` stays high for exactly `T_HI` cycles per pulse. `data_o` does not change while `dclk_o` is high, and `s_ready` is never asserted while `dclk_o` is high.
- R6: If `stat_i` is low during FETCH, LOW or HIGH, the block returns to idle with `err` set and `ok` clear.
- R7: After `done_i` is seen high, exactly two falling edges of `dclk_o` are issued. If `init_done_i` then rises, `ok` is set. `ok` only rises while `done_i` is high.
- R8: If `done_i` has not risen within `T_DONE_TMO` cycles after the last word, the block returns to idle with `tmo` set.
- R9: If `init_done_i` has not risen within `T_INIT_TMO` cycles after the second extra falling edge, the block returns to idle with `tmo` set.
- R10: If `stat_i` has not returned high within `T_STAT_TMO` cycles after the pulse, the block returns to idle with `tmo` set and no clock pulses.
- R11: Whenever the block is idle, `data_oe` is 0 and `dclk_o` is parked at 0. At most one of `ok`, `err` and `tmo` is set.
- R12: If status drops in the same cycle the last word's high phase ends, the abort wins: `err` is set and `ok` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (taken in idle only) |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_last | input | 1 | Marks final word of the image |
| s_ready | output | 1 | Word accepted this cycle |
| cfg_rst_n | output | 1 | Active-low configuration-reset strobe to target |
| stat_i | input | 1 | Target status line |
| done_i | input | 1 | Target done line |
| init_done_i | input | 1 | Target init-done line |
| dclk_o | output | 1 | Configuration clock |
| data_o | output | 16 | Parallel configuration data |
| data_oe | output | 1 | Output enable for `data_o` (0 = high impedance) |
| busy | output | 1 | Sequence in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load aborted by target status |
| tmo | output | 1 | Last load timed out |

## Verification
Two events can fall in the same system cycle: the end of the last word's high phase, which would lead on to the done wait and to success, and the target dropping its status line, which must abort. The bench's target model watches how long the final high phase has lasted. It pulls status low on the negative edge just before the phase expires, so the design sees both events at one rising edge. The outcome is judged at the ports: `err` must be set, `ok` must stay clear, and all words must still have been clocked out.

// File: rtl/cfg_host_pkg.sv
package cfg_host_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_WSTAT,
        ST_LEAD,
        ST_FETCH,
        ST_LOW,
        ST_HIGH,
        ST_WDONE,
        ST_XHIGH,
        ST_XLOW,
        ST_WINIT
    } seq_state_t;
endpackage

// File: rtl/cfg_interval_timer.sv
module cfg_interval_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cfg_bus_drv.sv
module cfg_bus_drv #(
    parameter int DW = 16,
    parameter int BW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] din,
    input  logic          din_last,
    input  logic          oe_en,
    output logic [BW-1:0] bus_o,
    output logic          bus_oe,
    output logic          last_q
);
    logic [DW-1:0] word_q;
    logic [BW-1:0] wide;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            last_q <= 1'b0;
        end else if (capture) begin
            word_q <= din;
            last_q <= din_last;
        end
    end

    generate
        if (BW > DW) begin : g_pad
            assign wide = {{(BW-DW){1'b0}}, word_q};
        end else begin : g_full
            assign wide = word_q[BW-1:0];
        end
    endgenerate

    assign bus_o  = oe_en ? wide : '0;
    assign bus_oe = oe_en;
endmodule

// File: rtl/cfg_host_seq.sv
module cfg_host_seq
    import cfg_host_pkg::*;
#(
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int T_PULSE     = 4,
    parameter int T_LEAD      = 3,
    parameter int T_LO        = 2,
    parameter int T_HI        = 2,
    parameter int T_STAT_TMO  = 64,
    parameter int T_DONE_TMO  = 32,
    parameter int T_INIT_TMO  = 32,
    parameter bit USE_INIT    = 1'b1,
    localparam int BW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    input  logic          s_last,
    output logic          s_ready,
    output logic          cfg_rst_n,
    input  logic          stat_i,
    input  logic          done_i,
    input  logic          init_done_i,
    output logic          dclk_o,
    output logic [BW-1:0] data_o,
    output logic          data_oe,
    output logic          busy,
    output logic          ok,
    output logic          err,
    output logic          tmo
);
    localparam logic [CW-1:0] L_PULSE = CW'(T_PULSE - 1);
    localparam logic [CW-1:0] L_LEAD  = CW'(T_LEAD - 1);
    localparam logic [CW-1:0] L_LO    = CW'(T_LO - 1);
    localparam logic [CW-1:0] L_HI    = CW'(T_HI - 1);
    localparam logic [CW-1:0] L_STAT  = CW'(T_STAT_TMO - 1);
    localparam logic [CW-1:0] L_DONE  = CW'(T_DONE_TMO - 1);
    localparam logic [CW-1:0] L_INIT  = CW'(T_INIT_TMO - 1);

    seq_state_t    st, st_d;
    logic          xcnt, x_d;
    logic          t_load, t_exp;
    logic [CW-1:0] t_val;
    logic          set_ok, set_err, set_tmo;
    logic          last_q, oe_en;

    cfg_interval_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_exp)
    );

    cfg_bus_drv #(.DW(DW), .BW(BW)) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (s_ready),
        .din      (s_data),
        .din_last (s_last),
        .oe_en    (oe_en),
        .bus_o    (data_o),
        .bus_oe   (data_oe),
        .last_q   (last_q)
    );

    // next-state and timer control
    always_comb begin
        st_d    = st;
        x_d     = xcnt;
        t_load  = 1'b0;
        t_val   = '0;
        set_ok  = 1'b0;
        set_err = 1'b0;
        set_tmo = 1'b0;
        unique case (st)
            ST_IDLE: if (start) begin
                st_d = ST_PULSE; t_load = 1'b1; t_val = L_PULSE;
            end
            ST_PULSE: if (t_exp) begin
                st_d = ST_WSTAT; t_load = 1'b1; t_val = L_STAT;
            end
            ST_WSTAT: begin
                if (stat_i) begin
                    st_d = ST_LEAD; t_load = 1'b1; t_val = L_LEAD;
                end else if (t_exp) begin
                    st_d = ST_IDLE; set_tmo = 1'b1;
                end
            end
            ST_LEAD: if (t_exp) st_d = ST_FETCH;
            ST_FETCH: begin
                if (!stat_i) begin
                    st_d = ST_IDLE; set_err = 1'b1;
                end else if (s_valid) begin
                    st_d = ST_LOW; t_load = 1'b1; t_val = L_LO;
                end
            end
            ST_LOW: begin
                if (!stat_i) begin
                    st_d = ST_IDLE; set_err = 1'b1;
                end else if (t_exp) begin
                    st_d = ST_HIGH; t_load = 1'b1; t_val = L_HI;
                end
            end
            ST_HIGH: begin
                if (!stat_i) begin
                    st_d = ST_IDLE; set_err = 1'b1;
                end else if (t_exp) begin
                    if (last_q) begin
                        st_d = ST_WDONE; t_load = 1'b1; t_val = L_DONE;
                    end else begin
                        st_d = ST_FETCH;
                    end
                end
            end
            ST_WDONE: begin
                if (done_i) begin
                    st_d = ST_XHIGH; t_load = 1'b1; t_val = L_HI; x_d = 1'b0;
                end else if (t_exp) begin
                    st_d = ST_IDLE; set_tmo = 1'b1;
                end
            end
            ST_XHIGH: if (t_exp) begin
                st_d = ST_XLOW; t_load = 1'b1; t_val = L_LO;
            end
            ST_XLOW: if (t_exp) begin
                if (!xcnt) begin
                    x_d = 1'b1; st_d = ST_XHIGH; t_load = 1'b1; t_val = L_HI;
                end else if (USE_INIT) begin
                    st_d = ST_WINIT; t_load = 1'b1; t_val = L_INIT;
                end else begin
                    st_d = ST_IDLE; set_ok = 1'b1;
                end
            end
            ST_WINIT: begin
                if (init_done_i) begin
                    st_d = ST_IDLE; set_ok = 1'b1;
                end else if (t_exp) begin
                    st_d = ST_IDLE; set_tmo = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // state register and result flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= ST_IDLE;
            xcnt <= 1'b0;
            ok   <= 1'b0;
            err  <= 1'b0;
            tmo  <= 1'b0;
        end else begin
            st   <= st_d;
            xcnt <= x_d;
            if (st == ST_IDLE && start) begin
                ok  <= 1'b0;
                err <= 1'b0;
                tmo <= 1'b0;
            end else begin
                if (set_ok)  ok  <= 1'b1;
                if (set_err) err <= 1'b1;
                if (set_tmo) tmo <= 1'b1;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        s_ready   = (st == ST_FETCH) && s_valid && stat_i;
        cfg_rst_n = (st != ST_PULSE);
        dclk_o    = (st == ST_HIGH) || (st == ST_XHIGH);
        busy      = (st != ST_IDLE);
        oe_en     = (st == ST_FETCH) || (st == ST_LOW) || (st == ST_HIGH) ||
                    (st == ST_WDONE) || (st == ST_XHIGH) || (st == ST_XLOW);
    end
endmodule

// File: rtl/cfg_host_chk.sv
module cfg_host_chk #(
    parameter int BW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready,
    input logic          cfg_rst_n,
    input logic          dclk_o,
    input logic [BW-1:0] data_o,
    input logic          data_oe,
    input logic          busy,
    input logic          ok,
    input logic          err,
    input logic          tmo,
    input logic          done_i
);
    p_strobe_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rst_n |-> busy);

    p_no_fetch_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !dclk_o);

    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk_o && $past(dclk_o)) |-> $stable(data_o));

    p_idle_parked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!data_oe && !dclk_o));

    p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok, err, tmo}));

    p_ok_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ok) |-> done_i);
endmodule

bind cfg_host_seq cfg_host_chk #(.BW(BW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .cfg_rst_n (cfg_rst_n),
    .dclk_o    (dclk_o),
    .data_o    (data_o),
    .data_oe   (data_oe),
    .busy      (busy),
    .ok        (ok),
    .err       (err),
    .tmo       (tmo),
    .done_i    (done_i)
);

// File: tb/cfg_host_seq_tb.sv
module cfg_host_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int PULSE = 4, LEAD = 3, LO = 2, HI = 2;
    localparam int STMO = 40, DTMO = 20, ITMO = 20;

    logic clk = 0, rst_n = 0, start = 0;
    logic s_valid = 0, s_last = 0, s_ready;
    logic [DW-1:0] s_data = '0;
    logic cfg_rst_n, dclk_o, data_oe, busy, ok, err, tmo;
    logic [15:0] data_o;
    logic stat = 1, done = 1, init = 1;

    int checks = 0, errors = 0;
    logic [15:0] exp_q[$];

    // target model controls and measurements
    bit no_stat, no_done, no_init, drop_mid, drop_last;
    int n_exp, rcv, post, hcnt, hi_len, pulse_cnt, scnt, cyc, stat_cyc, rise_cyc;
    bit dropped, prev_dclk;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_host_seq #(.DW(DW), .T_PULSE(PULSE), .T_LEAD(LEAD), .T_LO(LO), .T_HI(HI),
                   .T_STAT_TMO(STMO), .T_DONE_TMO(DTMO), .T_INIT_TMO(ITMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_data(s_data),
        .s_last(s_last), .s_ready(s_ready), .cfg_rst_n(cfg_rst_n), .stat_i(stat),
        .done_i(done), .init_done_i(init), .dclk_o(dclk_o), .data_o(data_o),
        .data_oe(data_oe), .busy(busy), .ok(ok), .err(err), .tmo(tmo));

    task automatic check(input bit cond, input string tag, input int act, input int expv);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] word(input int i);
        return 16'hA5C3 + 16'(i * 16'h0F1E);
    endfunction

    // target model plus scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            prev_dclk = 0;
        end else if (!cfg_rst_n) begin
            pulse_cnt++; stat = 0; done = 0; init = 0; rcv = 0; post = 0;
            dropped = 0; scnt = 0; hcnt = 0;
        end else begin
            if (!stat && !dropped && !no_stat) begin
                scnt++;
                if (scnt >= 3) begin stat = 1; stat_cyc = cyc; end
            end
            if (dclk_o) hcnt++;
            if (dclk_o && !prev_dclk && !done) begin
                rcv++;
                if (rcv == 1) rise_cyc = cyc;
                if (exp_q.size() == 0)
                    check(1'b0, "R4 unexpected word", data_o, 0);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(data_o === e, "R4 word on bus", data_o, e);
                end
            end
            if (!dclk_o && prev_dclk) begin
                hi_len = hcnt;
                if (done) post++;
                else if (rcv == n_exp && !no_done) done = 1;
            end
            if (!dclk_o) hcnt = 0;
            if (done && post == 2 && !no_init) init = 1;
            if (drop_mid && rcv == 2) begin stat = 0; dropped = 1; end
            if (drop_last && rcv == n_exp && hcnt == HI) begin stat = 0; dropped = 1; end
        end
        prev_dclk = dclk_o;
    end

    // driver: offers words and pushes them to the scoreboard on acceptance
    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            if (i % 2 == 1) begin s_valid = 0; @(negedge clk); end
            s_valid = 1; s_data = word(i); s_last = (i == n - 1);
            forever begin
                #1;
                if (s_ready || !busy) break;
                @(negedge clk);
            end
            if (!busy) break;
            exp_q.push_back(word(i));
            @(negedge clk);
        end
        s_valid = 0; s_last = 0;
    endtask

    task automatic run(input int n, input bit ns, input bit nd, input bit ni,
                       input bit dm, input bit dl);
        no_stat = ns; no_done = nd; no_init = ni; drop_mid = dm; drop_last = dl;
        n_exp = n; pulse_cnt = 0; hi_len = 0; rise_cyc = 0; stat_cyc = 0;
        exp_q.delete();
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        fork send(n); join_none
        for (int k = 0; k < 3000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cfg_rst_n && !dclk_o && !data_oe && !busy && !ok && !err && !tmo,
              "R1 reset state", {cfg_rst_n, dclk_o, data_oe, busy, ok, err, tmo}, 7'b1000000);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // normal load
        run(5, 0, 0, 0, 0, 0);
        check(ok && !err && !tmo, "R7 success flag", {ok, err, tmo}, 3'b100);
        check(post == 2, "R7 extra falling edges", post, 2);
        check(rcv == 5, "R4 word count", rcv, 5);
        check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
        check(pulse_cnt == PULSE, "R2 strobe length", pulse_cnt, PULSE);
        check(rise_cyc - stat_cyc >= LEAD + LO, "R3 lead-in", rise_cyc - stat_cyc, LEAD + LO);
        check(hi_len == HI, "R5 high phase", hi_len, HI);
        check(!data_oe && !dclk_o && !busy, "R11 bus released", {data_oe, dclk_o}, 0);

        // status drop mid stream
        run(5, 0, 0, 0, 1, 0);
        check(err && !ok && !tmo, "R6 abort flags", {ok, err, tmo}, 3'b010);
        check(rcv == 2, "R6 stopped after abort", rcv, 2);
        check(!data_oe && !busy, "R11 released after abort", data_oe, 0);

        // done never rises
        run(3, 0, 1, 0, 0, 0);
        check(tmo && !ok && !err, "R8 done timeout", {ok, err, tmo}, 3'b001);
        check(post == 0, "R8 no extra edges", post, 0);

        // init-done never rises
        run(3, 0, 0, 1, 0, 0);
        check(tmo && !ok, "R9 init timeout", {ok, err, tmo}, 3'b001);
        check(post == 2, "R9 extra edges sent", post, 2);

        // status never returns
        run(3, 1, 0, 0, 0, 0);
        check(tmo && !ok && !err, "R10 status timeout", {ok, err, tmo}, 3'b001);
        check(rcv == 0, "R10 no clocks", rcv, 0);

        // abort coincides with end of last word
        run(3, 0, 0, 0, 0, 1);
        check(err && !ok && !tmo, "R12 abort wins", {ok, err, tmo}, 3'b010);
        check(rcv == 3, "R12 all words clocked", rcv, 3);

        // recovery after faults
        run(4, 0, 0, 0, 0, 0);
        check(ok && !err && !tmo, "R7 recovery load", {ok, err, tmo}, 3'b100);
        check(exp_q.size() == 0 && rcv == 4, "R4 recovery words", rcv, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule